// File: doc/BRIEF.md
# Double-Buffered USB OUT Endpoint Packet Store

This block holds received data for one bulk-style OUT endpoint of a full-speed USB device controller. It has two packet buffers used in ping-pong fashion. The receive side sees an OUT token strobe, followed by start, byte, end and good-packet strobes from the packet engine. For each token the block gives an ACK or NAK decision, based on whether a buffer is free at that moment. A packet that ends bad, too long or empty is dropped without using a buffer.

The processor side drains the oldest stored packet through a 32-bit read port with the data byte in bits 7:0. Each read returns the next byte of the current packet. The port shows whether a packet is available and how long it is. When the last byte of a packet is read, its buffer is released and the other buffer becomes current. A read with nothing stored returns zero and pulses an underflow flag.

Top module: `usb_out_pingpong`

## Requirements
- R1: No more than two complete packets are held at once. `pkt_avail_o` is 1 whenever at least one packet is held.
- R2: An OUT token (`tok_out_i`) gets a decision on the next cycle: `hs_valid_o` is high for one cycle, and `hs_ack_o` is 1 for ACK or 0 for NAK. ACK is given when fewer than two packets are held in the token's cycle.
- R3: While both buffers hold packets, every token gets NAK, even while the current packet is partly read. The first token after the last byte of the current packet has been read gets ACK.
- R4: A read (`rd_en_i`) of an available packet returns that packet's next byte in `rd_data_o[7:0]` from the following cycle on. Bits 31:8 are always zero, and the port is 0x00 after reset.
- R5: Packets are drained in the order they were received. `pkt_len_o` shows the byte count of the current packet, and 0 when none is held.
- R6: A packet whose `rx_end_i` arrives with `rx_good_i` low is dropped. It takes no buffer, and the next good packet is stored from its first byte with no leftover data.
- R7: Bytes beyond `MAX_PKT` (default 64) are not stored, and such a packet is dropped at its end. A packet of exactly `MAX_PKT` bytes is kept whole.
- R8: A read when no packet is available returns 0 on the next cycle and raises `underflow_o` for that one cycle. It changes no stored data or read position.
- R9: Receive strobes that do not follow an ACKed token are ignored. This covers data sent after a NAK.
- R10: A good packet with zero bytes is acknowledged but not stored.
- R11: After reset: `pkt_avail_o`=0, `pkt_len_o`=0, `hs_valid_o`=0, `underflow_o`=0, `rd_data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_out_i | input | 1 | OUT token addressed to this endpoint |
| hs_valid_o | output | 1 | Handshake decision valid (one cycle) |
| hs_ack_o | output | 1 | 1 = ACK, 0 = NAK |
| rx_start_i | input | 1 | Start of data packet |
| rx_vld_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_end_i | input | 1 | End of data packet |
| rx_good_i | input | 1 | Packet passed checks (read with rx_end_i) |
| rd_en_i | input | 1 | Processor read of the data port |
| rd_data_o | output | 32 | Read data, byte in bits 7:0 |
| pkt_avail_o | output | 1 | A complete packet is ready |
| pkt_len_o | output | 7 | Byte count of the current packet |
| underflow_o | output | 1 | Previous read found no packet |

## Verification
Every result is registered exactly once. The handshake decision appears one cycle after the token. Read data and the underflow pulse appear one cycle after the read. Availability and length change one cycle after the end strobe or after the read of a packet's final byte. The bench drives inputs on the falling edge and checks on the next falling edge, which is the first point after the one rising edge that produces each result. The underflow pulse is checked again one cycle later to confirm that it has cleared.

// File: rtl/oep_pkg.sv
package oep_pkg;
   localparam int unsigned OEP_NBUF = 2;
   typedef enum logic {HS_NAK = 1'b0, HS_ACK = 1'b1} oep_hs_e;
endpackage

// File: rtl/oep_occupancy.sv
module oep_occupancy
   import oep_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic commit_i,
   input  logic release_i,
   output logic head_o,
   output logic tail_o,
   output logic avail_o,
   output logic has_free_o
);
   localparam logic [1:0] FULL = 2'(OEP_NBUF);

   logic [1:0] cnt_q;
   logic       head_q, tail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         head_q <= 1'b0;
         tail_q <= 1'b0;
      end else begin
         if (commit_i)  tail_q <= ~tail_q;
         if (release_i) head_q <= ~head_q;
         case ({commit_i, release_i})
            2'b10:   cnt_q <= cnt_q + 2'd1;
            2'b01:   cnt_q <= cnt_q - 2'd1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head_o     = head_q;
   assign tail_o     = tail_q;
   assign avail_o    = (cnt_q != 2'd0);
   assign has_free_o = (cnt_q != FULL);

   // R1
   occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);
   // R1
   no_commit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |-> (cnt_q != FULL));
   // R4
   no_release_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_i |-> (cnt_q != 2'd0));
endmodule

// File: rtl/oep_rx_ctl.sv
module oep_rx_ctl
   import oep_pkg::*;
#(
   parameter int unsigned MAX_PKT = 64,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned AW = $clog2(MAX_PKT),
   localparam int unsigned LW = $clog2(MAX_PKT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_i,
   input  logic              has_free_i,
   input  logic              rx_start_i,
   input  logic              rx_vld_i,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic              rx_end_i,
   input  logic              rx_good_i,
   output logic              hs_valid_o,
   output logic              hs_ack_o,
   output logic              wr_en_o,
   output logic [AW-1:0]     wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              commit_o,
   output logic [LW-1:0]     commit_len_o
);
   localparam logic [LW-1:0] LIMIT = LW'(MAX_PKT);

   logic          armed_q, err_q, hs_valid_q;
   oep_hs_e       hs_q;
   logic [LW-1:0] cnt_q;
   logic          fits, spill;
   logic [LW-1:0] len_now;

   assign fits      = (cnt_q < LIMIT);
   assign wr_en_o   = armed_q && rx_vld_i && !rx_start_i && fits;
   assign spill     = armed_q && rx_vld_i && !rx_start_i && !fits;
   assign wr_addr_o = cnt_q[AW-1:0];
   assign wr_data_o = rx_data_i;
   assign len_now   = cnt_q + (wr_en_o ? LW'(1) : LW'(0));

   assign commit_o     = armed_q && rx_end_i && rx_good_i && !err_q && !spill
                         && (len_now != '0);
   assign commit_len_o = len_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         err_q      <= 1'b0;
         cnt_q      <= '0;
         hs_valid_q <= 1'b0;
         hs_q       <= HS_NAK;
      end else if (tok_i) begin
         hs_valid_q <= 1'b1;
         hs_q       <= has_free_i ? HS_ACK : HS_NAK;
         armed_q    <= has_free_i;
         cnt_q      <= '0;
         err_q      <= 1'b0;
      end else begin
         hs_valid_q <= 1'b0;
         if (armed_q) begin
            if (rx_end_i) begin
               armed_q <= 1'b0;
               cnt_q   <= '0;
               err_q   <= 1'b0;
            end else if (rx_start_i) begin
               cnt_q <= '0;
               err_q <= 1'b0;
            end else begin
               if (wr_en_o) cnt_q <= cnt_q + LW'(1);
               if (spill)   err_q <= 1'b1;
            end
         end
      end
   end

   assign hs_valid_o = hs_valid_q;
   assign hs_ack_o   = (hs_q == HS_ACK);

   // R2
   ack_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_i && has_free_i) |=> (hs_valid_o && hs_ack_o));
   // R3
   nak_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_i && !has_free_i) |=> (hs_valid_o && !hs_ack_o));
   // R9
   nak_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid_o && !hs_ack_o) |-> (!wr_en_o && !commit_o));
   // R7
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> (commit_len_o <= LIMIT && commit_len_o != '0));
endmodule

// File: rtl/oep_bank.sv
module oep_bank
   import oep_pkg::*;
#(
   parameter int unsigned MAX_PKT = 64,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned AW = $clog2(MAX_PKT),
   localparam int unsigned LW = $clog2(MAX_PKT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [AW-1:0]     wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              commit_i,
   input  logic [LW-1:0]     commit_len_i,
   input  logic              rd_sel_i,
   input  logic [AW-1:0]     rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [LW-1:0]     rd_len_o
);
   logic [DATA_W-1:0] rdat [OEP_NBUF];
   logic [LW-1:0]     lens [OEP_NBUF];

   for (genvar g = 0; g < OEP_NBUF; g++) begin : g_buf
      logic [DATA_W-1:0] mem [MAX_PKT];
      logic [LW-1:0]     len_q;
      logic              sel_wr;

      assign sel_wr = (wr_sel_i == 1'(g));

      always_ff @(posedge clk) begin
         if (wr_en_i && sel_wr) mem[wr_addr_i] <= wr_data_i;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                len_q <= '0;
         else if (commit_i && sel_wr) len_q <= commit_len_i;
      end

      assign rdat[g] = mem[rd_addr_i];
      assign lens[g] = len_q;
   end

   assign rd_data_o = rdat[rd_sel_i];
   assign rd_len_o  = lens[rd_sel_i];
endmodule

// File: rtl/oep_rd_ctl.sv
module oep_rd_ctl
   import oep_pkg::*;
#(
   parameter int unsigned MAX_PKT = 64,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned BUS_W   = 32,
   localparam int unsigned AW = $clog2(MAX_PKT),
   localparam int unsigned LW = $clog2(MAX_PKT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_i,
   input  logic              avail_i,
   input  logic [LW-1:0]     len_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [AW-1:0]     rd_addr_o,
   output logic              release_o,
   output logic [BUS_W-1:0]  rd_data_o,
   output logic              underflow_o
);
   logic [AW-1:0]    ptr_q;
   logic [BUS_W-1:0] data_q;
   logic             undf_q;
   logic             pop, last;

   assign pop       = rd_en_i && avail_i;
   assign last      = ((LW'(ptr_q) + LW'(1)) == len_i);
   assign release_o = pop && last;
   assign rd_addr_o = ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         data_q <= '0;
         undf_q <= 1'b0;
      end else begin
         undf_q <= rd_en_i && !avail_i;
         if (pop) begin
            data_q <= BUS_W'(mem_data_i);
            ptr_q  <= last ? '0 : ptr_q + AW'(1);
         end else if (rd_en_i) begin
            data_q <= '0;
         end
      end
   end

   assign rd_data_o   = data_q;
   assign underflow_o = undf_q;

   // R8
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !avail_i) |=> (underflow_o && rd_data_o == '0));
   // R8
   empty_read_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !avail_i) |=> $stable(ptr_q));
   // R4
   ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      avail_i |-> (LW'(ptr_q) < len_i));
endmodule

// File: rtl/usb_out_pingpong.sv
module usb_out_pingpong
   import oep_pkg::*;
#(
   parameter int unsigned MAX_PKT = 64,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned BUS_W   = 32,
   localparam int unsigned AW = $clog2(MAX_PKT),
   localparam int unsigned LW = $clog2(MAX_PKT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_out_i,
   output logic              hs_valid_o,
   output logic              hs_ack_o,
   input  logic              rx_start_i,
   input  logic              rx_vld_i,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic              rx_end_i,
   input  logic              rx_good_i,
   input  logic              rd_en_i,
   output logic [BUS_W-1:0]  rd_data_o,
   output logic              pkt_avail_o,
   output logic [LW-1:0]     pkt_len_o,
   output logic              underflow_o
);
   if (MAX_PKT < 2 || MAX_PKT > 1024) begin : g_bad_max_pkt
      $error("MAX_PKT must lie in 2..1024");
   end
   if (BUS_W < DATA_W) begin : g_bad_bus_w
      $error("BUS_W must be at least DATA_W");
   end

   logic              head, tail, avail, has_free;
   logic              wr_en, commit, release_pkt;
   logic [AW-1:0]     wr_addr, rd_addr;
   logic [DATA_W-1:0] wr_data, mem_data;
   logic [LW-1:0]     commit_len, cur_len;

   oep_occupancy u_occ (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_i   (commit),
      .release_i  (release_pkt),
      .head_o     (head),
      .tail_o     (tail),
      .avail_o    (avail),
      .has_free_o (has_free)
   );

   oep_rx_ctl #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W)) u_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .tok_i        (tok_out_i),
      .has_free_i   (has_free),
      .rx_start_i   (rx_start_i),
      .rx_vld_i     (rx_vld_i),
      .rx_data_i    (rx_data_i),
      .rx_end_i     (rx_end_i),
      .rx_good_i    (rx_good_i),
      .hs_valid_o   (hs_valid_o),
      .hs_ack_o     (hs_ack_o),
      .wr_en_o      (wr_en),
      .wr_addr_o    (wr_addr),
      .wr_data_o    (wr_data),
      .commit_o     (commit),
      .commit_len_o (commit_len)
   );

   oep_bank #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en_i      (wr_en),
      .wr_sel_i     (tail),
      .wr_addr_i    (wr_addr),
      .wr_data_i    (wr_data),
      .commit_i     (commit),
      .commit_len_i (commit_len),
      .rd_sel_i     (head),
      .rd_addr_i    (rd_addr),
      .rd_data_o    (mem_data),
      .rd_len_o     (cur_len)
   );

   oep_rd_ctl #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_en_i     (rd_en_i),
      .avail_i     (avail),
      .len_i       (cur_len),
      .mem_data_i  (mem_data),
      .rd_addr_o   (rd_addr),
      .release_o   (release_pkt),
      .rd_data_o   (rd_data_o),
      .underflow_o (underflow_o)
   );

   assign pkt_avail_o = avail;
   assign pkt_len_o   = avail ? cur_len : '0;

   // R5
   len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_avail_o |-> (pkt_len_o != '0));
   // R10
   empty_pkt_not_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_avail_o && rx_end_i && !rx_vld_i && !tok_out_i && !rd_en_i
       && $past(rx_start_i)) |=> !pkt_avail_o);
endmodule

// File: tb/tb_usb_out_pingpong.sv
`timescale 1ns/1ps
module tb_usb_out_pingpong;
   localparam int MAXP = 64;
   localparam int LW   = $clog2(MAXP + 1);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          tok, start, vld, eop, good, rd_en;
   logic [7:0]    rxd;
   logic          hs_valid, hs_ack, avail, undf;
   logic [31:0]   rdata;
   logic [LW-1:0] plen;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   usb_out_pingpong #(.MAX_PKT(MAXP)) dut (
      .clk(clk), .rst_n(rst_n), .tok_out_i(tok),
      .hs_valid_o(hs_valid), .hs_ack_o(hs_ack),
      .rx_start_i(start), .rx_vld_i(vld), .rx_data_i(rxd),
      .rx_end_i(eop), .rx_good_i(good), .rd_en_i(rd_en),
      .rd_data_o(rdata), .pkt_avail_o(avail), .pkt_len_o(plen),
      .underflow_o(undf)
   );

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((seed + i * 5) & 8'hff);
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic token(input bit exp_ack, input string req);
      @(negedge clk); tok = 1'b1;
      @(negedge clk); tok = 1'b0;
      chk(32'(hs_valid), 32'd1, req);
      chk(32'(hs_ack), 32'(exp_ack), req);
      @(negedge clk);
      chk(32'(hs_valid), 32'd0, req);
   endtask

   task automatic send_data(input int n, input int seed, input bit ok);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < n; i++) begin
         vld = 1'b1; rxd = pat(seed, i);
         @(negedge clk);
      end
      vld = 1'b0; eop = 1'b1; good = ok;
      @(negedge clk); eop = 1'b0; good = 1'b0;
   endtask

   task automatic read_bytes(input int first, input int cnt, input int seed, input string req);
      for (int i = first; i < first + cnt; i++) begin
         rd_en = 1'b1;
         @(negedge clk); rd_en = 1'b0;
         chk(rdata, {24'h0, pat(seed, i)}, req);
      end
   endtask

   // R11 R4 R5: reset state
   task automatic t_reset();
      chk(32'(avail), 0, "R11");
      chk(32'(plen), 0, "R5");
      chk(32'(hs_valid), 0, "R11");
      chk(32'(undf), 0, "R11");
      chk(rdata, 0, "R4");
   endtask

   // R4 R5: one packet through
   task automatic t_single();
      token(1'b1, "R2");
      send_data(5, 10, 1'b1);
      chk(32'(avail), 1, "R1");
      chk(32'(plen), 5, "R5");
      read_bytes(0, 5, 10, "R4");
      chk(32'(avail), 0, "R4");
   endtask

   // R1 R2 R3 R9 R5: fill both, NAK, drain, order
   task automatic t_fill();
      token(1'b1, "R2"); send_data(3, 20, 1'b1);
      token(1'b1, "R2"); send_data(4, 30, 1'b1);
      token(1'b0, "R2");
      send_data(6, 99, 1'b1);
      chk(32'(plen), 3, "R9");
      read_bytes(0, 2, 20, "R4");
      token(1'b0, "R3");
      read_bytes(2, 1, 20, "R4");
      chk(32'(avail), 1, "R1");
      chk(32'(plen), 4, "R5");
      token(1'b1, "R3");
      send_data(2, 40, 1'b1);
      read_bytes(0, 4, 30, "R5");
      chk(32'(plen), 2, "R5");
      read_bytes(0, 2, 40, "R5");
      chk(32'(avail), 0, "R5");
   endtask

   // R6: bad packet dropped
   task automatic t_bad();
      token(1'b1, "R6"); send_data(6, 70, 1'b0);
      chk(32'(avail), 0, "R6");
      token(1'b1, "R6"); send_data(2, 50, 1'b1);
      chk(32'(plen), 2, "R6");
      read_bytes(0, 2, 50, "R6");
   endtask

   // R7: overflow dropped, exact maximum kept
   task automatic t_ovf();
      token(1'b1, "R7"); send_data(MAXP + 3, 60, 1'b1);
      chk(32'(avail), 0, "R7");
      token(1'b1, "R7"); send_data(MAXP, 80, 1'b1);
      chk(32'(plen), MAXP, "R7");
      read_bytes(0, MAXP, 80, "R7");
      chk(32'(avail), 0, "R7");
   endtask

   // R8: empty read
   task automatic t_underflow();
      rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      chk(rdata, 0, "R8");
      chk(32'(undf), 1, "R8");
      @(negedge clk);
      chk(32'(undf), 0, "R8");
      token(1'b1, "R8"); send_data(3, 90, 1'b1);
      read_bytes(0, 1, 90, "R8");
      chk(32'(undf), 0, "R8");
      read_bytes(1, 2, 90, "R8");
   endtask

   // R10 R9: empty packet, strobes without token
   task automatic t_misc();
      token(1'b1, "R10"); send_data(0, 0, 1'b1);
      chk(32'(avail), 0, "R10");
      send_data(4, 11, 1'b1);
      chk(32'(avail), 0, "R9");
   endtask

   initial begin
      rst_n = 1'b0; tok = 0; start = 0; vld = 0; eop = 0; good = 0; rd_en = 0; rxd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_fill();
      t_bad();
      t_ovf();
      t_underflow();
      t_misc();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule